// File: doc/BRIEF.md
# Parallel Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands and returns the full-width signed product one clock after the operands are presented. The multiplier operand (A) is recoded into radix-4 signed digits drawn from {-2, -1, 0, +1, +2}. Each digit selects a scaled copy of the multiplicand (B) to form one partial product. All partial products are formed at the same time and summed by one combinational adder. The sum is captured in an output register.

Recoding pads A with a zero below its least significant bit. It then reads overlapping three-bit windows that step by two bit positions, so an MP_W-bit multiplier yields only MP_W/2 partial products instead of MP_W. The operand widths are parameters, and the multiplier width must be even. A caller raises `in_valid` together with the operands. Exactly one cycle later, `out_valid` pulses and `out_product` carries the result. A new operand pair may be presented on every cycle.

Top module: `booth_mul_r4`

## Requirements
- R1: For every operand pair accepted with `in_valid` high, `out_product` equals the signed product A×B, represented in MC_W+MP_W bits.
- R2: The recoder pads A with a 0 at bit position -1. Window k reads A bits (2k+1, 2k, 2k-1). Its digit is bit(2k-1) + bit(2k) - 2·bit(2k+1), so the codes map as follows: 000 and 111 give 0, 001 and 010 give +B, 011 gives +2B, 100 gives -2B, and 101 and 110 give -B.
- R3: Exactly MP_W/2 partial products are formed. Partial product k is sign-extended to MC_W+MP_W bits and weighted by 4^k, which is a left shift of 2k bits. ±2B is B shifted left by one, and negative selections are two's-complement negations.
- R4: The most negative operands are handled without overflow. At 4 bits, -8×-8 = +64 (0x40) and -8×7 = -56 (0xC8). At 8 bits, -128×-128 = +16384 (0x4000) and -128×127 = -16256 (0xC080).
- R5: At 4 bits, A = -7 and B = -3 give +21. The two windows recode to +B (k=0) and -2B (k=1).
- R6: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. Back-to-back inputs give back-to-back results.
- R7: While `in_valid` is low, `out_product` holds its last value whatever the operand inputs do.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_product` is 0.
- R9: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| in_a | input | MP_W | Multiplier operand A, signed, Booth recoded |
| in_b | input | MC_W | Multiplicand operand B, signed |
| out_valid | output | 1 | One-cycle pulse marking a new product |
| out_product | output | MC_W+MP_W | Registered signed product |

## Verification
At 4 bits, the bench sweeps all 256 signed pairs. A recoder that mishandled the padded bit -1 or the top window, which reads the real sign bit, would give wrong results for odd or negative multipliers. A partial product not sign-extended to full width would corrupt every negative result. At 8 bits, random pairs are checked along with the extreme values, where a -2B formed at operand width rather than product width would wrap and return a product of the wrong sign. Idle cycles with the operand inputs still changing expose a register that reloads without `in_valid`. Back-to-back inputs expose a valid pulse that is stretched or dropped.

// File: rtl/booth_mul_pkg.sv
`timescale 1ns/1ps
package booth_mul_pkg;

  // Selection for one radix-4 digit; encoding is internal only.
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_POS1 = 3'd1,
    DIG_POS2 = 3'd2,
    DIG_NEG1 = 3'd5,
    DIG_NEG2 = 3'd6
  } digit_e;

  // Window bits {hi, mid, lo} = A(2k+1), A(2k), A(2k-1).
  function automatic digit_e recode_window(input logic [2:0] win);
    digit_e d;
    case (win)
      3'b001, 3'b010: d = DIG_POS1;
      3'b011:         d = DIG_POS2;
      3'b100:         d = DIG_NEG2;
      3'b101, 3'b110: d = DIG_NEG1;
      default:        d = DIG_ZERO;
    endcase
    return d;
  endfunction

  // Numeric value of a digit, used by checks.
  function automatic int digit_value(input digit_e d);
    int v;
    case (d)
      DIG_POS1: v = 1;
      DIG_POS2: v = 2;
      DIG_NEG1: v = -1;
      DIG_NEG2: v = -2;
      default:  v = 0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
`timescale 1ns/1ps
module booth_recoder
  import booth_mul_pkg::*;
#(
  parameter int MP_W = 8
) (
  input  logic [MP_W-1:0] mplier,
  output digit_e          digit [MP_W/2]
);
  localparam int NGRP = MP_W / 2;

  // Zero appended below the LSB (bit position -1).
  logic [MP_W:0] padded;
  assign padded = {mplier, 1'b0};

  for (genvar k = 0; k < NGRP; k++) begin : g_win
    assign digit[k] = recode_window(padded[2*k+2 : 2*k]);
  end

  // R2: the weighted digit sum must rebuild the signed multiplier.
  always_comb begin
    longint acc;
    acc = 0;
    for (int k = 0; k < NGRP; k++) begin
      acc = acc + (longint'(digit_value(digit[k])) <<< (2 * k));
    end
    assert_recode_value_R2 : assert (acc == longint'($signed(mplier)));
  end

endmodule

// File: rtl/booth_ppgen.sv
`timescale 1ns/1ps
module booth_ppgen
  import booth_mul_pkg::*;
#(
  parameter int MC_W = 8,
  parameter int MP_W = 8
) (
  input  logic [MC_W-1:0]      mcand,
  input  digit_e               digit [MP_W/2],
  output logic [MC_W+MP_W-1:0] pp    [MP_W/2]
);
  localparam int NGRP = MP_W / 2;
  localparam int PW   = MC_W + MP_W;

  // Multiples formed once at full product width.
  logic [PW-1:0] b_pos1, b_pos2, b_neg1, b_neg2;
  assign b_pos1 = {{MP_W{mcand[MC_W-1]}}, mcand};
  assign b_pos2 = b_pos1 << 1;
  assign b_neg1 = -b_pos1;
  assign b_neg2 = -b_pos2;

  for (genvar k = 0; k < NGRP; k++) begin : g_pp
    logic [PW-1:0] chosen;
    always_comb begin
      case (digit[k])
        DIG_POS1: chosen = b_pos1;
        DIG_POS2: chosen = b_pos2;
        DIG_NEG1: chosen = b_neg1;
        DIG_NEG2: chosen = b_neg2;
        default:  chosen = '0;
      endcase
    end
    // Weight 4^k.
    assign pp[k] = chosen << (2 * k);
  end

endmodule

// File: rtl/booth_sum.sv
`timescale 1ns/1ps
module booth_sum #(
  parameter int PW   = 16,
  parameter int NGRP = 4
) (
  input  logic [PW-1:0] pp [NGRP],
  output logic [PW-1:0] total
);
  always_comb begin
    total = '0;
    for (int k = 0; k < NGRP; k++) begin
      total = total + pp[k];
    end
  end
endmodule

// File: rtl/booth_mul_r4.sv
`timescale 1ns/1ps
module booth_mul_r4
  import booth_mul_pkg::*;
#(
  parameter int MC_W = 8,
  parameter int MP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [MP_W-1:0]      in_a,
  input  logic [MC_W-1:0]      in_b,
  output logic                 out_valid,
  output logic [MC_W+MP_W-1:0] out_product
);
  localparam int NGRP = MP_W / 2;
  localparam int PW   = MC_W + MP_W;

  digit_e        digit_w [NGRP];
  logic [PW-1:0] pp_w    [NGRP];
  logic [PW-1:0] sum_w;

  booth_recoder #(.MP_W(MP_W)) u_recoder (
    .mplier (in_a),
    .digit  (digit_w)
  );

  booth_ppgen #(.MC_W(MC_W), .MP_W(MP_W)) u_ppgen (
    .mcand (in_b),
    .digit (digit_w),
    .pp    (pp_w)
  );

  booth_sum #(.PW(PW), .NGRP(NGRP)) u_sum (
    .pp    (pp_w),
    .total (sum_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_product <= sum_w;
    end
  end

  // Behavioural product, used only by the assertions.
  logic [PW-1:0] ref_w;
  assign ref_w = $signed({{MC_W{in_a[MP_W-1]}}, in_a}) *
                 $signed({{MP_W{in_b[MC_W-1]}}, in_b});

  assert_product_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_product == $past(ref_w));

  assert_valid_follows_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_product));

  assert_zero_operand_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_a == '0 || in_b == '0)) |=> out_product == '0);

endmodule

// File: tb/tb_booth_mul_r4.sv
`timescale 1ns/1ps
module tb_booth_mul_r4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       v4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       ov4;
  logic [7:0] p4;

  logic       v8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       ov8;
  logic [15:0] p8;

  booth_mul_r4 #(.MC_W(4), .MP_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(v4), .in_a(a4), .in_b(b4),
    .out_valid(ov4), .out_product(p4));

  booth_mul_r4 #(.MC_W(8), .MP_W(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .in_valid(v8), .in_a(a8), .in_b(b8),
    .out_valid(ov8), .out_product(p8));

  int checks = 0;
  int failures = 0;
  string cur_tag = "R8";
  bit finished = 1'b0;

  // Behavioural reference: integer multiply registered on accepted inputs.
  logic        mv4, mv8;
  logic [7:0]  mp4;
  logic [15:0] mp8;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv4 <= 1'b0; mp4 <= '0; mv8 <= 1'b0; mp8 <= '0;
    end else begin
      mv4 <= v4;
      mv8 <= v8;
      if (v4) mp4 <= 8'(int'($signed(a4)) * int'($signed(b4)));
      if (v8) mp8 <= 16'(int'($signed(a8)) * int'($signed(b8)));
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Compared on every clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (!finished) begin
      chk("R6 valid 4b", 32'(ov4), 32'(mv4));
      chk({cur_tag, " product 4b"}, 32'(p4), 32'(mp4));
      chk("R6 valid 8b", 32'(ov8), 32'(mv8));
      chk({cur_tag, " product 8b"}, 32'(p8), 32'(mp8));
    end
  end

  task automatic drive4(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk); v4 = 1'b1; a4 = a; b4 = b;
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk); v8 = 1'b1; a8 = a; b8 = b;
  endtask

  task automatic idle();
    @(negedge clk); v4 = 1'b0; v8 = 1'b0;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // R8: reset state
    #7;
    chk("R8 reset valid 4b", 32'(ov4), 32'd0);
    chk("R8 reset product 4b", 32'(p4), 32'd0);
    chk("R8 reset valid 8b", 32'(ov8), 32'd0);
    chk("R8 reset product 8b", 32'(p8), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // R5: worked example
    cur_tag = "R5";
    drive4(4'b1001, 4'b1101);
    @(posedge clk); #1;
    chk("R5 -7 x -3", 32'(p4), 32'd21);
    chk("R6 pulse after R5 input", 32'(ov4), 32'd1);
    idle();

    // R4: extreme operands
    cur_tag = "R4";
    drive4(4'b1000, 4'b1000); drive8(8'h80, 8'h80);
    @(posedge clk); #1;
    chk("R4 -8 x -8", 32'(p4), 32'h40);
    chk("R4 -128 x -128", 32'(p8), 32'h4000);
    drive4(4'b1000, 4'b0111); drive8(8'h80, 8'h7F);
    @(posedge clk); #1;
    chk("R4 -8 x 7", 32'(p4), 32'hC8);
    chk("R4 -128 x 127", 32'(p8), 32'hC080);
    idle();

    // R9: zero operands
    cur_tag = "R9";
    drive4(4'b0000, 4'b1011);
    @(posedge clk); #1;
    chk("R9 0 x -5", 32'(p4), 32'd0);
    drive4(4'b1101, 4'b0000);
    @(posedge clk); #1;
    chk("R9 -3 x 0", 32'(p4), 32'd0);
    idle();

    // R7: hold while idle, operands still moving
    cur_tag = "R7";
    drive4(4'd3, 4'd5);
    @(negedge clk); v4 = 1'b0; a4 = 4'd7; b4 = 4'd7;
    @(negedge clk); a4 = 4'b1001; b4 = 4'd2;
    @(negedge clk); a4 = 4'd6;
    @(posedge clk); #1;
    chk("R7 held product", 32'(p4), 32'd15);
    chk("R7 no valid while idle", 32'(ov4), 32'd0);

    // R1 R2 R3 R6: exhaustive 4-bit sweep, back to back
    cur_tag = "R1 R2 R3";
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        drive4(4'(i), 4'(j));
      end
    end
    idle();

    // R1 R3: random 8-bit pairs with occasional gaps
    cur_tag = "R1 R3 random";
    for (int n = 0; n < 1500; n++) begin
      drive8(8'($urandom), 8'($urandom));
      if (n % 37 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule